// File: doc/BRIEF.md
# Receive Packet Classifier and Demux

This block sits on the receive side of a PCI Express transaction layer and steers every incoming packet, whole, to one of ten output streams. It looks only at the first header doubleword of the start-of-packet word and decodes the format and type fields into a 2-bit class code: request, completion, message or error. Requests are then split again by a one-hot BAR-hit sideband into a 3-bit BAR code. The class code and the BAR code go out with every word as channel fields, so a plain stream demux further downstream can use them without decoding the header again.

The route is decided combinationally on the first word of a packet and latched when that word is accepted. It then stays fixed for every word up to and including the end-of-packet word, whatever those later words carry. Data, SOP, EOP and the empty count pass through unchanged on a shared bus. Each output has its own valid and ready. Back-pressure works like this: the input is ready exactly when the currently selected output is ready. A stall on any other output has no effect. Nothing is buffered, so a word is accepted on a clock edge only when in_valid and in_ready are both high.

A BAR pair mask parameter marks which adjacent slot pairs (0-1, 2-3, 4-5) form one 64-bit BAR. A hit on the upper slot of such a pair is reported with the lower slot's code.

Top module: `rx_tlp_classifier`

## Requirements
- R1: The header doubleword is bits [31:0] of the SOP word, with fmt in bits [31:29] and type in bits [28:24]. Class 00 (request) is given to type 00000 with fmt 000..011, type 00001 with fmt 000 or 001, and type 00010 with fmt 000 or 010.
- R2: Class 01 (completion) is given to type 01010 or 01011 with fmt 000 or 010. Class 10 (message) is given to type 10xxx with fmt 001 or 011. Every other fmt/type pair gets class 11 (error), and that includes every fmt of 1xx.
- R3: The class and BAR codes decided on the first word of a packet are held on out_class and out_bar for every later word through EOP, whatever header bits or BAR hits those words carry. The next word after an accepted EOP is decoded afresh.
- R4: For a request, out_bar is the index of the lowest set bit of in_bar_hit[6:0]. Codes 000..101 are BAR0..BAR5 and 110 is the expansion ROM.
- R5: When bit p of BAR_PAIR_MASK is set, slots 2p and 2p+1 form one 64-bit BAR, and a hit on slot 2p+1 is reported as code 2p.
- R6: A packet that decodes as a request but has no BAR hit bit set is routed with class 11.
- R7: Output index k in 0..6 carries requests with BAR code k. Index 7 carries completions, 8 carries messages and 9 carries errors. While in_valid is high, exactly the selected out_valid bit is high.
- R8: in_ready equals out_ready of the selected output. A word presented while that output is not ready is not accepted and does not start a packet.
- R9: out_data, out_sop, out_eop and out_empty equal the corresponding inputs. out_bar is 111 for any packet whose class is not 00.
- R10: While in_valid is low, every out_valid bit is low. After reset no packet is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word accepted when high with in_valid |
| in_data | input | DATA_W | Packet word; header doubleword in [31:0] on SOP |
| in_sop | input | 1 | First word of packet |
| in_eop | input | 1 | Last word of packet |
| in_empty | input | EMPTY_W | Unused byte count on the last word |
| in_bar_hit | input | 7 | One-hot BAR hit sideband, sampled on the first word |
| out_valid | output | 10 | Per-output valid, at most one set |
| out_ready | input | 10 | Per-output ready |
| out_data | output | DATA_W | Shared data to all outputs |
| out_sop | output | 1 | Shared SOP |
| out_eop | output | 1 | Shared EOP |
| out_empty | output | EMPTY_W | Shared empty count |
| out_class | output | 2 | Class channel code |
| out_bar | output | 3 | BAR channel code, 111 when not a request |

## Verification
The path from input to outputs has no register, so a decode error in the class table or the BAR priority shows up on out_class, out_bar and out_valid in the same cycle the SOP word is presented. The only state is the latched route and its in-packet flag. If the flag is wrong, the next SOP either inherits the previous packet's channel codes or a mid-packet word switches output. Either fault shows within one word of the packet boundary. A wrong ready select shows as in_ready following an output that is not the one asserting valid.

// File: rtl/rxc_pkg.sv
package rxc_pkg;
  // Fixed routing geometry: six BAR slots plus the expansion ROM.
  localparam int unsigned NUM_SLOTS = 7;
  localparam int unsigned NUM_PAIRS = (NUM_SLOTS - 1) / 2;
  localparam int unsigned NUM_OUT   = NUM_SLOTS + 3;
  localparam int unsigned OUT_CPL   = NUM_SLOTS;
  localparam int unsigned OUT_MSG   = NUM_SLOTS + 1;
  localparam int unsigned OUT_ERR   = NUM_SLOTS + 2;
  localparam int unsigned BAR_W     = 3;
  localparam logic [BAR_W-1:0] BAR_NONE = 3'b111;

  typedef enum logic [1:0] {
    CLS_REQ = 2'b00,
    CLS_CPL = 2'b01,
    CLS_MSG = 2'b10,
    CLS_ERR = 2'b11
  } cls_e;
endpackage

// File: rtl/rxc_hdr_decode.sv
// Header doubleword decode: fmt/type to class code.
module rxc_hdr_decode
  import rxc_pkg::*;
(
  input  logic [31:0] hdr_dw,
  output cls_e        cls
);
  logic [2:0] fmt;
  logic [4:0] typ;
  logic       fmt_rd;     // no data, 3 or 4 DW header
  logic       fmt_any;    // any fmt without prefix
  logic       fmt_nd_wd;  // 3DW without data or 3DW with data

  assign fmt       = hdr_dw[31:29];
  assign typ       = hdr_dw[28:24];
  assign fmt_any   = (fmt[2] == 1'b0);
  assign fmt_rd    = (fmt[2:1] == 2'b00);
  assign fmt_nd_wd = (fmt == 3'b000) || (fmt == 3'b010);

  always_comb begin
    cls = CLS_ERR;
    if (typ[4:3] == 2'b10) begin
      // message family, routing subfield in typ[2:0]
      if ((fmt == 3'b001) || (fmt == 3'b011)) begin
        cls = CLS_MSG;
      end
    end else begin
      case (typ)
        5'b00000: if (fmt_any)   cls = CLS_REQ;
        5'b00001: if (fmt_rd)    cls = CLS_REQ;
        5'b00010: if (fmt_nd_wd) cls = CLS_REQ;
        5'b01010,
        5'b01011: if (fmt_nd_wd) cls = CLS_CPL;
        default:                 cls = CLS_ERR;
      endcase
    end
  end
endmodule

// File: rtl/rxc_bar_select.sv
// BAR hit folding for 64-bit pairs, then lowest-index priority.
module rxc_bar_select
  import rxc_pkg::*;
#(
  parameter logic [NUM_PAIRS-1:0] PAIR_MASK = '0
) (
  input  logic [NUM_SLOTS-1:0] hit,
  output logic [BAR_W-1:0]     code,
  output logic                 any_hit
);
  logic [NUM_SLOTS-1:0] folded;

  // Pairs cover slots 0..NUM_PAIRS*2-1; the ROM slot never pairs.
  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    if (PAIR_MASK[p]) begin : g_wide
      assign folded[2*p]   = hit[2*p] | hit[2*p+1];
      assign folded[2*p+1] = 1'b0;
    end else begin : g_narrow
      assign folded[2*p]   = hit[2*p];
      assign folded[2*p+1] = hit[2*p+1];
    end
  end
  for (genvar s = 2 * NUM_PAIRS; s < NUM_SLOTS; s++) begin : g_single
    assign folded[s] = hit[s];
  end

  always_comb begin
    code = BAR_NONE;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (folded[i]) code = BAR_W'(i);
    end
  end

  assign any_hit = |folded;
endmodule

// File: rtl/rxc_route_ctl.sv
// Latches the route chosen on the first word and holds it through EOP.
module rxc_route_ctl
  import rxc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic             last,
  input  cls_e             dec_cls,
  input  logic [BAR_W-1:0] dec_bar,
  output cls_e             cur_cls,
  output logic [BAR_W-1:0] cur_bar
);
  logic             busy;
  cls_e             held_cls;
  logic [BAR_W-1:0] held_bar;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      held_cls <= CLS_ERR;
      held_bar <= BAR_NONE;
    end else if (fire) begin
      if (!busy) begin
        held_cls <= dec_cls;
        held_bar <= dec_bar;
      end
      busy <= !last;
    end
  end

  assign cur_cls = busy ? held_cls : dec_cls;
  assign cur_bar = busy ? held_bar : dec_bar;
endmodule

// File: rtl/rx_tlp_classifier.sv
// Receive packet classifier: class + BAR routing onto ten output streams.
module rx_tlp_classifier
  import rxc_pkg::*;
#(
  parameter int unsigned          DATA_W        = 64,
  parameter int unsigned          EMPTY_W       = 1,
  parameter logic [NUM_PAIRS-1:0] BAR_PAIR_MASK = '0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [DATA_W-1:0]    in_data,
  input  logic                 in_sop,
  input  logic                 in_eop,
  input  logic [EMPTY_W-1:0]   in_empty,
  input  logic [NUM_SLOTS-1:0] in_bar_hit,
  output logic [NUM_OUT-1:0]   out_valid,
  input  logic [NUM_OUT-1:0]   out_ready,
  output logic [DATA_W-1:0]    out_data,
  output logic                 out_sop,
  output logic                 out_eop,
  output logic [EMPTY_W-1:0]   out_empty,
  output logic [1:0]           out_class,
  output logic [BAR_W-1:0]     out_bar
);
  cls_e             hdr_cls;
  cls_e             dec_cls;
  cls_e             cur_cls;
  logic [BAR_W-1:0] hit_code;
  logic [BAR_W-1:0] dec_bar;
  logic [BAR_W-1:0] cur_bar;
  logic             hit_any;
  logic             fire;
  logic [NUM_OUT-1:0] sel_oh;

  rxc_hdr_decode u_hdr (
    .hdr_dw (in_data[31:0]),
    .cls    (hdr_cls)
  );

  rxc_bar_select #(
    .PAIR_MASK (BAR_PAIR_MASK)
  ) u_bar (
    .hit     (in_bar_hit),
    .code    (hit_code),
    .any_hit (hit_any)
  );

  // A request without a BAR hit cannot be delivered to a BAR output.
  always_comb begin
    dec_cls = hdr_cls;
    dec_bar = BAR_NONE;
    if (hdr_cls == CLS_REQ) begin
      if (hit_any) dec_bar = hit_code;
      else         dec_cls = CLS_ERR;
    end
  end

  assign fire = in_valid && in_ready;

  rxc_route_ctl u_route (
    .clk     (clk),
    .rst_n   (rst_n),
    .fire    (fire),
    .last    (in_eop),
    .dec_cls (dec_cls),
    .dec_bar (dec_bar),
    .cur_cls (cur_cls),
    .cur_bar (cur_bar)
  );

  // One-hot output select.
  for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_bar_out
    assign sel_oh[k] = (cur_cls == CLS_REQ) && (cur_bar == BAR_W'(k));
  end
  assign sel_oh[OUT_CPL] = (cur_cls == CLS_CPL);
  assign sel_oh[OUT_MSG] = (cur_cls == CLS_MSG);
  assign sel_oh[OUT_ERR] = (cur_cls == CLS_ERR);

  assign in_ready  = |(sel_oh & out_ready);
  assign out_valid = in_valid ? sel_oh : '0;

  assign out_data  = in_data;
  assign out_sop   = in_sop;
  assign out_eop   = in_eop;
  assign out_empty = in_empty;
  assign out_class = cur_cls;
  assign out_bar   = cur_bar;
endmodule

// File: rtl/rxc_classifier_chk.sv
// Port-level checker bound to the classifier.
module rxc_classifier_chk
  import rxc_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic               in_ready,
  input logic               in_eop,
  input logic [NUM_OUT-1:0] out_valid,
  input logic [NUM_OUT-1:0] out_ready,
  input logic [1:0]         out_class,
  input logic [BAR_W-1:0]   out_bar
);
  logic             mid;
  logic [1:0]       last_cls;
  logic [BAR_W-1:0] last_bar;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mid      <= 1'b0;
      last_cls <= 2'b11;
      last_bar <= BAR_NONE;
    end else if (in_valid && in_ready) begin
      if (!mid) begin
        last_cls <= out_class;
        last_bar <= out_bar;
      end
      mid <= !in_eop;
    end
  end

  a_r7_one_valid: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ($countones(out_valid) == 1));

  a_r10_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> (out_valid == '0));

  a_r8_ready_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> (in_ready == |(out_valid & out_ready)));

  a_r3_route_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mid && in_valid) |-> ((out_class == last_cls) && (out_bar == last_bar)));

  a_r9_bar_none: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (out_class != 2'b00)) |-> (out_bar == BAR_NONE));

  a_r7_err_map: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid[OUT_ERR] |-> (out_class == 2'b11));

  a_r7_cpl_map: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid[OUT_CPL] |-> (out_class == 2'b01));
endmodule

bind rx_tlp_classifier rxc_classifier_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_eop    (in_eop),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_class (out_class),
  .out_bar   (out_bar)
);

// File: tb/rx_tlp_classifier_tb.sv
module rx_tlp_classifier_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [2:0] PAIRS = 3'b010;  // slots 2-3 form one 64-bit BAR

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_data = '0;
  logic        in_sop = 1'b0;
  logic        in_eop = 1'b0;
  logic [0:0]  in_empty = '0;
  logic [6:0]  in_bar_hit = '0;
  logic [9:0]  out_valid;
  logic [9:0]  out_ready = '1;
  logic [63:0] out_data;
  logic        out_sop;
  logic        out_eop;
  logic [0:0]  out_empty;
  logic [1:0]  out_class;
  logic [2:0]  out_bar;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  rx_tlp_classifier #(
    .DATA_W (64), .EMPTY_W (1), .BAR_PAIR_MASK (PAIRS)
  ) u_dut (
    .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .in_ready (in_ready),
    .in_data (in_data), .in_sop (in_sop), .in_eop (in_eop), .in_empty (in_empty),
    .in_bar_hit (in_bar_hit), .out_valid (out_valid), .out_ready (out_ready),
    .out_data (out_data), .out_sop (out_sop), .out_eop (out_eop),
    .out_empty (out_empty), .out_class (out_class), .out_bar (out_bar)
  );

  task automatic chk(input logic [63:0] got, input logic [63:0] exp, input string req);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  function automatic logic [63:0] hdr(input logic [2:0] f, input logic [4:0] t);
    return {32'hC0DE_0000 ^ {27'd0, t}, f, t, 24'h00_0010};
  endfunction

  // Class from requirements R1, R2, R6.
  function automatic logic [1:0] ref_cls(input logic [2:0] f, input logic [4:0] t,
                                         input logic [6:0] hit);
    logic req, cpl, msg;
    req = (t == 5'd0 && f <= 3'd3) || (t == 5'd1 && f <= 3'd1) ||
          (t == 5'd2 && (f == 3'd0 || f == 3'd2));
    cpl = (t == 5'd10 || t == 5'd11) && (f == 3'd0 || f == 3'd2);
    msg = (t >= 5'd16 && t <= 5'd23) && (f == 3'd1 || f == 3'd3);
    if (req) return (hit == 7'd0) ? 2'd3 : 2'd0;
    if (cpl) return 2'd1;
    if (msg) return 2'd2;
    return 2'd3;
  endfunction

  // BAR code from R4, R5 with slots 2-3 paired.
  function automatic logic [2:0] ref_bar(input logic [6:0] hit);
    for (int i = 0; i < 7; i++) begin
      if (hit[i]) return (i == 3) ? 3'd2 : 3'(i);
    end
    return 3'd7;
  endfunction

  function automatic logic [9:0] ref_vld(input logic [1:0] c, input logic [2:0] b);
    case (c)
      2'd0:    return 10'd1 << b;
      2'd1:    return 10'd1 << 7;
      2'd2:    return 10'd1 << 8;
      default: return 10'd1 << 9;
    endcase
  endfunction

  task automatic put(input logic [63:0] d, input logic s, input logic e,
                     input logic [6:0] hit, input logic [9:0] rdy);
    @(negedge clk);
    in_data = d; in_sop = s; in_eop = e; in_bar_hit = hit;
    out_ready = rdy; in_valid = 1'b1;
    #1;
  endtask

  task automatic expect_route(input logic [1:0] c, input logic [2:0] b, input string req);
    chk(64'(out_class), 64'(c), req);
    chk(64'(out_bar), 64'(c == 2'd0 ? b : 3'd7), req);
    chk(64'(out_valid), 64'(ref_vld(c, c == 2'd0 ? b : 3'd7)), req);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    // R10: idle during and after reset
    #2;
    chk(64'(out_valid), 64'd0, "R10 reset idle");
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(64'(out_valid), 64'd0, "R10 no valid out");

    // R1, R2, R6, R7: every fmt/type pair, single-word packets
    for (int k = 0; k < 256; k++) begin
      logic [2:0] f;
      logic [4:0] t;
      logic [6:0] hit;
      logic [1:0] c;
      f = 3'(k >> 5);
      t = 5'(k);
      hit = ((k % 8) == 7) ? 7'd0 : 7'(1 << (k % 8));
      c = ref_cls(f, t, hit);
      put(hdr(f, t), 1'b1, 1'b1, hit, '1);
      expect_route(c, ref_bar(hit), (c == 2'd0) ? "R1 request" : "R2 class");
      chk(64'(in_ready), 64'd1, "R8 ready");
    end

    // R4, R5, R6: every BAR hit pattern on a memory read
    for (int h = 0; h < 128; h++) begin
      put(hdr(3'd0, 5'd0), 1'b1, 1'b1, 7'(h), '1);
      expect_route(ref_cls(3'd0, 5'd0, 7'(h)), ref_bar(7'(h)), "R4 R5 bar");
    end
    put(hdr(3'd2, 5'd0), 1'b1, 1'b1, 7'b1000000, '1);
    expect_route(2'd0, 3'd6, "R4 rom");
    put(hdr(3'd2, 5'd0), 1'b1, 1'b1, 7'b0001000, '1);
    expect_route(2'd0, 3'd2, "R5 upper slot folded");
    put(hdr(3'd2, 5'd0), 1'b1, 1'b1, 7'b0000010, '1);
    expect_route(2'd0, 3'd1, "R5 unpaired slot kept");

    // R9: passthrough of data and framing
    in_empty = 1'b1;
    put(64'hFEED_BEEF_4A00_0001, 1'b1, 1'b1, 7'b0100000, '1);
    chk(out_data, 64'hFEED_BEEF_4A00_0001, "R9 data");
    chk(64'({out_sop, out_eop, out_empty}), 64'd7, "R9 flags");
    expect_route(2'd1, 3'd7, "R9 bar none");
    in_empty = 1'b0;

    // R3: completion packet whose later words look like other headers
    put(hdr(3'd2, 5'd10), 1'b1, 1'b0, 7'd0, '1);
    expect_route(2'd1, 3'd7, "R3 first");
    put(hdr(3'd0, 5'd0), 1'b0, 1'b0, 7'b0000001, '1);
    expect_route(2'd1, 3'd7, "R3 middle");
    // R8: stall selected output mid-packet
    put(hdr(3'd1, 5'd16), 1'b0, 1'b0, 7'b0000100, 10'h37F);
    chk(64'(in_ready), 64'd0, "R8 mid stall");
    expect_route(2'd1, 3'd7, "R3 stalled");
    put(hdr(3'd1, 5'd16), 1'b0, 1'b1, 7'b0000100, 10'h080);
    chk(64'(in_ready), 64'd1, "R8 only selected ready");
    expect_route(2'd1, 3'd7, "R3 last");
    // next packet decoded afresh
    put(hdr(3'd3, 5'd0), 1'b1, 1'b1, 7'b0100000, '1);
    expect_route(2'd0, 3'd5, "R3 new packet");

    // R8: stalled first word is not accepted
    put(hdr(3'd2, 5'd10), 1'b1, 1'b0, 7'd0, 10'h37F);
    chk(64'(in_ready), 64'd0, "R8 stall first");
    put(hdr(3'd0, 5'd0), 1'b1, 1'b1, 7'b0000001, '1);
    expect_route(2'd0, 3'd0, "R8 no packet started");

    // R3: multi-word request packet, hits change after first word
    put(hdr(3'd3, 5'd0), 1'b1, 1'b0, 7'b0010000, '1);
    expect_route(2'd0, 3'd4, "R3 req first");
    put(64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 1'b1, 7'b0000001, '1);
    expect_route(2'd0, 3'd4, "R3 req last");

    @(negedge clk);
    in_valid = 1'b0;
    #1;
    chk(64'(out_valid), 64'd0, "R10 idle after traffic");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule